// File: doc/BRIEF.md
# Duty-Cycled Hysteretic Field Latch Controller

This block runs a low-power magnetic sensor on a fixed duty cycle. A slow clock drives it. A short awake phase, in which the sensor front end is powered, alternates with a long sleep phase, in which the front end is switched off. Near the end of each awake phase, after a settling delay, the block offers to take one signed field sample from a digitizer. It takes the sample through a valid/ready handshake.

An accepted sample is compared against two signed thresholds:
- An upper threshold, the operate point. A field strictly above it switches the latched output on.
- A lower threshold, the release point. A field strictly below it switches the output off.
- Any field between the two thresholds leaves the output unchanged.

Turning the output on and back off therefore takes fields of both signs. The output holds its value through every sleep phase and through every cycle in which no sample is taken. A polarity input negates the sample before the compare, which models a sensor mounted the other way round.

The sample port is a stream with these rules. `samp_rdy_o` is a one-cycle offer, made exactly once per awake phase. A transfer happens only when `samp_vld_i` is high in that same cycle. The block never stalls and never waits for the producer. If the producer is not valid in the offered cycle, that phase's evaluation is forfeited and the output holds. The block keeps no copy of any sample.

Top module: `duty_latch_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pwr_en_o` is 1, `out_on_o` is 0 and `samp_rdy_o` is 0 (for SETTLE_CYC > 0). The first awake phase begins in the first cycle after reset is released.
- R2: `pwr_en_o` is high for exactly AWAKE_CYC consecutive cycles and then low for exactly SLEEP_CYC consecutive cycles, repeating without a gap.
- R3: `samp_rdy_o` is high for exactly one cycle per awake phase: the cycle with 0-based index SETTLE_CYC counted from the phase's first cycle. It is never high while `pwr_en_o` is low.
- R4: A sample transfers only when `samp_rdy_o` and `samp_vld_i` are both high. If `samp_vld_i` is low in the offered cycle, `out_on_o` keeps its value.
- R5: If the transferred field (the sample, read as two's complement) is strictly greater than OP_THR, `out_on_o` is 1 from the next cycle on.
- R6: If the transferred field is strictly less than REL_THR, `out_on_o` is 0 from the next cycle on.
- R7: If the transferred field lies in the inclusive range REL_THR to OP_THR, `out_on_o` is unchanged.
- R8: When `pol_rev_i` is 1 in the transfer cycle, the field is the negated sample, computed one bit wider so that the most negative sample does not overflow.
- R9: `out_on_o` does not change during the sleep phase.
- R10: `samp_data_i`, `samp_vld_i` and `pol_rev_i` have no effect on `out_on_o` in any cycle without a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow sequencing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pol_rev_i | input | 1 | 1 = negate the sample before the compare |
| samp_vld_i | input | 1 | Sample valid from the digitizer |
| samp_data_i | input | SAMPLE_W | Signed field sample |
| samp_rdy_o | output | 1 | One-cycle sample offer (ready) |
| pwr_en_o | output | 1 | Sensor front-end power enable |
| out_on_o | output | 1 | Latched output state, 1 = on |

## Verification
The hard part is reaching the compare boundaries: a sample exactly at either threshold, one count beyond it, or the most negative code under reversed polarity. Each of these must land in the single offered cycle of a window. The bench's model predicts which cycle that is and drives a queue of chosen sample, polarity and valid values in exactly that cycle. One queued entry leaves valid low to forfeit a window. In every other cycle the bench drives random and extreme data with random valid, so that any leak of input outside a transfer shows up at the output.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic {
    PH_AWAKE = 1'b0,
    PH_SLEEP = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } act_e;

endpackage

// File: rtl/dlc_sequencer.sv
module dlc_sequencer
  import dlc_pkg::*;
#(
  parameter int AWAKE_CYC  = 12,
  parameter int SLEEP_CYC  = 7000,
  parameter int SETTLE_CYC = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pwr_en_o,
  output logic strobe_o
);

  localparam int MAX_CYC = (AWAKE_CYC > SLEEP_CYC) ? AWAKE_CYC : SLEEP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] AW_LAST = CNT_W'(AWAKE_CYC - 1);
  localparam logic [CNT_W-1:0] SL_LAST = CNT_W'(SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0] ST_IDX  = CNT_W'(SETTLE_CYC);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (phase_q)
      PH_AWAKE: begin
        if (cnt_q == AW_LAST) begin
          phase_d = PH_SLEEP;
          cnt_d   = '0;
        end
      end
      PH_SLEEP: begin
        if (cnt_q == SL_LAST) begin
          phase_d = PH_AWAKE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pwr_en_o = (phase_q == PH_AWAKE);
  assign strobe_o = (phase_q == PH_AWAKE) && (cnt_q == ST_IDX);

endmodule

// File: rtl/dlc_field_cmp.sv
module dlc_field_cmp
  import dlc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int OP_THR   = 30,
  parameter int REL_THR  = -30
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                pol_rev_i,
  output act_e                act_o
);

  localparam int EXT_W = SAMPLE_W + 1;
  localparam logic signed [EXT_W-1:0] OP_T  = $signed(EXT_W'(OP_THR));
  localparam logic signed [EXT_W-1:0] REL_T = $signed(EXT_W'(REL_THR));

  logic signed [EXT_W-1:0] ext_s;
  logic signed [EXT_W-1:0] fld_s;

  always_comb begin
    ext_s = $signed({sample_i[SAMPLE_W-1], sample_i});
    fld_s = pol_rev_i ? -ext_s : ext_s;
    if (fld_s > OP_T) begin
      act_o = ACT_SET;
    end else if (fld_s < REL_T) begin
      act_o = ACT_CLR;
    end else begin
      act_o = ACT_HOLD;
    end
  end

endmodule

// File: rtl/dlc_hold_reg.sv
module dlc_hold_reg
  import dlc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  act_e act_i,
  output logic on_o
);

  logic on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q <= 1'b0;
    end else if (take_i) begin
      unique case (act_i)
        ACT_SET: on_q <= 1'b1;
        ACT_CLR: on_q <= 1'b0;
        default: on_q <= on_q;
      endcase
    end
  end

  assign on_o = on_q;

endmodule

// File: rtl/duty_latch_ctrl.sv
module duty_latch_ctrl
  import dlc_pkg::*;
#(
  parameter int AWAKE_CYC  = 12,
  parameter int SLEEP_CYC  = 7000,
  parameter int SETTLE_CYC = 11,
  parameter int SAMPLE_W   = 12,
  parameter int OP_THR     = 30,
  parameter int REL_THR    = -30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pol_rev_i,
  input  logic                samp_vld_i,
  input  logic [SAMPLE_W-1:0] samp_data_i,
  output logic                samp_rdy_o,
  output logic                pwr_en_o,
  output logic                out_on_o
);

  logic strobe;
  logic take;
  act_e act;

  dlc_sequencer #(
    .AWAKE_CYC (AWAKE_CYC),
    .SLEEP_CYC (SLEEP_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_en_o(pwr_en_o),
    .strobe_o(strobe)
  );

  dlc_field_cmp #(
    .SAMPLE_W(SAMPLE_W),
    .OP_THR  (OP_THR),
    .REL_THR (REL_THR)
  ) u_cmp (
    .sample_i (samp_data_i),
    .pol_rev_i(pol_rev_i),
    .act_o    (act)
  );

  assign take = strobe && samp_vld_i;

  dlc_hold_reg u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .act_i (act),
    .on_o  (out_on_o)
  );

  assign samp_rdy_o = strobe;

endmodule

// File: rtl/dlc_chk.sv
module dlc_chk #(
  parameter int AWAKE_CYC  = 12,
  parameter int SLEEP_CYC  = 7000,
  parameter int SAMPLE_W   = 12,
  parameter int OP_THR     = 30,
  parameter int REL_THR    = -30
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pol_rev_i,
  input logic                samp_vld_i,
  input logic [SAMPLE_W-1:0] samp_data_i,
  input logic                samp_rdy_o,
  input logic                pwr_en_o,
  input logic                out_on_o
);

  int   fld;
  int   run_q;
  logic prev_q;
  logic xfer;

  always_comb begin
    fld  = pol_rev_i ? -int'($signed(samp_data_i)) : int'($signed(samp_data_i));
    xfer = samp_rdy_o && samp_vld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      run_q  <= 0;
    end else begin
      prev_q <= pwr_en_o;
      run_q  <= (pwr_en_o == prev_q) ? run_q + 1 : 1;
    end
  end

  // R2
  awake_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o && prev_q) |-> (run_q < AWAKE_CYC));

  // R2
  sleep_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_o && !prev_q) |-> (run_q < SLEEP_CYC));

  // R3
  offer_in_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_rdy_o |-> pwr_en_o);

  // R3
  offer_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_rdy_o |=> !samp_rdy_o);

  // R5
  set_above_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && (fld > OP_THR)) |=> out_on_o);

  // R6
  clr_below_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && (fld < REL_THR)) |=> !out_on_o);

  // R7
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && (fld <= OP_THR) && (fld >= REL_THR)) |=> $stable(out_on_o));

  // R10
  no_xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(out_on_o));

  // R9
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_o && !$past(pwr_en_o)) |-> $stable(out_on_o));

endmodule

bind duty_latch_ctrl dlc_chk #(
  .AWAKE_CYC(AWAKE_CYC),
  .SLEEP_CYC(SLEEP_CYC),
  .SAMPLE_W (SAMPLE_W),
  .OP_THR   (OP_THR),
  .REL_THR  (REL_THR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pol_rev_i  (pol_rev_i),
  .samp_vld_i (samp_vld_i),
  .samp_data_i(samp_data_i),
  .samp_rdy_o (samp_rdy_o),
  .pwr_en_o   (pwr_en_o),
  .out_on_o   (out_on_o)
);

// File: tb/duty_latch_ctrl_tb.sv
module duty_latch_ctrl_tb;

  localparam int A   = 5;
  localparam int S   = 23;
  localparam int ST  = 3;
  localparam int W   = 8;
  localparam int OP  = 30;
  localparam int REL = -30;
  localparam int P   = A + S;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pol = 1'b0;
  logic         vld = 1'b0;
  logic [W-1:0] data = '0;
  logic         rdy, pwr, out_on;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  int    dq_d[$];
  bit    dq_p[$];
  bit    dq_v[$];
  int    ph;
  bit    on_m;
  string otag;

  always #10 clk = ~clk;

  duty_latch_ctrl #(
    .AWAKE_CYC (A),
    .SLEEP_CYC (S),
    .SETTLE_CYC(ST),
    .SAMPLE_W  (W),
    .OP_THR    (OP),
    .REL_THR   (REL)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pol_rev_i  (pol),
    .samp_vld_i (vld),
    .samp_data_i(data),
    .samp_rdy_o (rdy),
    .pwr_en_o   (pwr),
    .out_on_o   (out_on)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errs++;
      checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<=200000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at t=%0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic queue_one(input bit v, input bit p, input int d);
    dq_v.push_back(v);
    dq_p.push_back(p);
    dq_d.push_back(d);
  endtask

  function automatic int rand_extreme();
    case ($urandom % 5)
      0: return 127;
      1: return -128;
      2: return 100;
      3: return -100;
      default: return int'($signed(8'($urandom)));
    endcase
  endfunction

  initial begin
    // Boundary sequence, one entry per offered cycle; output starts off
    queue_one(1, 0, 31);    // R5 set
    queue_one(1, 0, 30);    // R7 equal to operate point, hold on
    queue_one(1, 0, -30);   // R7 equal to release point, hold on
    queue_one(1, 0, -31);   // R6 clear
    queue_one(0, 0, 100);   // R4 forfeited window, stays off
    queue_one(1, 0, 0);     // R7 hold off
    queue_one(1, 1, -31);   // R8 reversed: field +31, set
    queue_one(1, 1, 31);    // R8 reversed: field -31, clear
    queue_one(1, 1, -128);  // R8 reversed most negative: field +128, set
    queue_one(1, 0, -128);  // R6 clear
    queue_one(1, 1, 127);   // R8 field -127, stays off
    queue_one(1, 0, 127);   // R5 set

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", pwr, 1'b1);
      chk("R1", out_on, 1'b0);
      chk("R1", rdy, 1'b0);
    end

    rst_n = 1'b1;
    ph    = 0;
    on_m  = 1'b0;
    otag  = "R1";

    for (int i = 0; i < 60 * P; i++) begin
      int  d;
      bit  p;
      bit  v;
      int  f;
      chk("R2", pwr, logic'(ph < A));
      chk("R3", rdy, logic'(ph == ST));
      chk(otag, out_on, on_m);

      if (ph == ST) begin
        if (dq_d.size() > 0) begin
          d = dq_d.pop_front();
          p = dq_p.pop_front();
          v = dq_v.pop_front();
        end else begin
          d = int'($signed(8'($urandom)));
          p = bit'($urandom % 2);
          v = ($urandom % 4) != 0;
        end
      end else begin
        d = rand_extreme();
        p = bit'($urandom % 2);
        v = bit'($urandom % 2);
      end
      data = W'(d);
      pol  = p;
      vld  = v;

      if (ph == ST && v) begin
        f = p ? -d : d;
        if (f > OP) begin
          on_m = 1'b1;
          otag = p ? "R8" : "R5";
        end else if (f < REL) begin
          on_m = 1'b0;
          otag = p ? "R8" : "R6";
        end else begin
          otag = "R7";
        end
      end else if (ph == ST) begin
        otag = "R4";
      end else begin
        otag = (ph < A) ? "R10" : "R9";
      end
      ph = (ph + 1) % P;
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule